// File: doc/BRIEF.md
# Float-to-Integer Converter with Selectable Overflow Policies

This unit turns a 64-bit IEEE754 binary64 value into a 32-bit or 64-bit integer, signed or unsigned, for an integer register write port. One datapath serves three policies for values that do not fit and for special inputs. The first saturates and sends NaN to the smallest integer of the target. The second saturates and sends NaN to zero. The third wraps modulo 2^N and sends infinities and NaN to zero. A separate control either uses a supplied dynamic rounding mode or forces truncation toward zero. Single-precision operands are expected to arrive already widened to binary64.

The unit has one register stage. A request presented with `in_valid` high appears on the outputs one clock later. The outputs are the 64-bit result, an invalid-operation flag, an inexact flag and, when requested, a three-bit compare-with-zero field for the condition register.

Top module: `f2i_convert`

## Requirements
- R1: The outputs register the conversion of the inputs sampled on a rising edge with `in_valid` high. `out_valid` equals `in_valid` from the previous edge. Edges with `in_valid` low leave `result`, `invalid`, `inexact` and `cr_field` unchanged.
- R2: The effective rounding follows `rmode`: 00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward -infinity. When `force_trunc` is 1, rounding is toward zero whatever `rmode` holds.
- R3: With `policy` = 00 (saturate), a rounded value above the target maximum gives the maximum and one below the target minimum gives the minimum, and `invalid` is raised. NaN gives the minimum valid integer (0x8000_0000_0000_0000 for signed 64, 0xFFFF_FFFF_8000_0000 for signed 32, 0 for unsigned) with `invalid` raised.
- R4: With `policy` = 01 (saturate, NaN to zero), out-of-range values saturate as in R3 and NaN gives 0. Both raise `invalid`.
- R5: With `policy` = 10 (wrap), the rounded value is reduced modulo 2^N (N = 32 or 64) and the low N bits are taken as the result. Infinities and NaN give 0. `invalid` is never raised.
- R6: `policy` = 11 behaves exactly like `policy` = 00.
- R7: For unsigned targets under a saturating policy, a negative input whose rounded value is nonzero gives 0 and raises `invalid`. A negative input that rounds to zero gives 0 without `invalid`.
- R8: For 32-bit targets (`wide64` = 0), bits 63:32 of `result` copy bit 31 when `signed_out` = 1 and are zero when `signed_out` = 0.
- R9: `inexact` is raised when rounding discarded nonzero fraction bits and `invalid` is not raised. `invalid` and `inexact` are never both high.
- R10: `cr_field` is {lt, gt, eq}, comparing `result` as a signed 64-bit number with zero, when `rc_en` was 1. It is 000 when `rc_en` was 0.
- R11: While `rst_n` is low, all outputs are zero.
- R12: Zeros and subnormal inputs give 0, or ±1 under a directed rounding mode that moves away from zero. Any nonzero subnormal raises `inexact`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| fp_in | input | 64 | binary64 operand |
| policy | input | 2 | 00 saturate, 01 saturate NaN-to-zero, 10 wrap, 11 as 00 |
| force_trunc | input | 1 | 1 forces rounding toward zero |
| rmode | input | 2 | Dynamic rounding mode (see R2) |
| wide64 | input | 1 | 1 selects a 64-bit target, 0 a 32-bit target |
| signed_out | input | 1 | 1 selects a signed target |
| rc_en | input | 1 | Requests the compare-with-zero field |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Integer result, extended to 64 bits |
| invalid | output | 1 | Invalid-operation flag |
| inexact | output | 1 | Inexact flag |
| cr_field | output | 3 | {lt, gt, eq} of the result, or 000 |

## Verification
The bench builds the unit with its default widths, a binary64 operand and a 64-bit destination with a 32-bit half target. Both target widths are reached at run time through `wide64`, so every saturation bound, NaN word and wrap boundary for 32 and 64 bits is covered in one build. Random exponents are concentrated in the range where integers cross 2^31, 2^32, 2^63 and 2^64. Each rounding mode therefore meets ties, carries into the bound and values just past each limit. Fully random and subnormal exponents reach the huge-value wrap path and the tiny-value rounding path.

// File: rtl/f2i_pkg.sv
// Shared widths and encodings for the float-to-integer converter.
// Assumes a binary64 operand and a 64-bit integer destination.
package f2i_pkg;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int FP_W   = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int XLEN   = 64;
    localparam int HALF   = XLEN / 2;

    typedef enum logic [1:0] {
        POL_SAT  = 2'b00,
        POL_SATZ = 2'b01,
        POL_WRAP = 2'b10,
        POL_ALT  = 2'b11
    } policy_e;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } rmode_e;
endpackage

// File: rtl/f2i_unpack.sv
// Splits a binary64 operand into sign, special-value class, integer part
// and the guard/sticky bits of the discarded fraction.
// Assumes magnitudes of 2^64 and above only need their low XLEN bits (big set).
module f2i_unpack
    import f2i_pkg::*;
(
    input  logic [FP_W-1:0] fp,
    output logic            sign,
    output logic            is_nan,
    output logic            is_inf,
    output logic            big,
    output logic [XLEN-1:0] int_part,
    output logic            guard,
    output logic            sticky
);
    localparam int WIDE_W   = 2 * XLEN;
    localparam int SH_CLAMP = WIDE_W - 1;
    localparam int BIG_SH   = XLEN - FRAC_W;
    localparam int R_BIAS   = BIAS + FRAC_W;
    localparam int FAR      = SIG_W + 1;
    localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

    logic [EXP_W-1:0]  expo;
    logic [EXP_W-1:0]  expo_eff;
    logic [FRAC_W-1:0] frac;
    logic [SIG_W-1:0]  sig;
    logic [WIDE_W-1:0] wide;
    logic [XLEN-1:0]   sig_x;
    logic [XLEN-1:0]   low_mask;
    logic [XLEN-1:0]   frac_bits;
    logic [XLEN-1:0]   half_bit;
    int                sh;
    int                shl;
    int                rsh;

    assign sign     = fp[FP_W-1];
    assign expo     = fp[FP_W-2 -: EXP_W];
    assign frac     = fp[FRAC_W-1:0];
    assign is_nan   = (&expo) & (|frac);
    assign is_inf   = (&expo) & ~(|frac);
    assign sig      = {|expo, frac};
    assign expo_eff = (expo == '0) ? {{(EXP_W-1){1'b0}}, 1'b1} : expo;
    assign sig_x    = {{(XLEN-SIG_W){1'b0}}, sig};

    // Place the significand relative to the binary point and collect rounding bits.
    always_comb begin
        sh        = int'(expo_eff) - R_BIAS;
        shl       = 0;
        rsh       = 1;
        wide      = '0;
        low_mask  = '0;
        frac_bits = '0;
        half_bit  = '0;
        int_part  = '0;
        guard     = 1'b0;
        sticky    = 1'b0;
        big       = 1'b0;
        if (sh >= 0) begin
            shl      = (sh > SH_CLAMP) ? SH_CLAMP : sh;
            wide     = {{(WIDE_W-SIG_W){1'b0}}, sig} << shl;
            int_part = wide[XLEN-1:0];
            big      = (sh >= BIG_SH);
        end else begin
            rsh       = (-sh > FAR) ? FAR : -sh;
            int_part  = sig_x >> rsh;
            low_mask  = (ONE << rsh) - ONE;
            frac_bits = sig_x & low_mask;
            half_bit  = ONE << (rsh - 1);
            guard     = |(frac_bits & half_bit);
            sticky    = |(frac_bits & (half_bit - ONE));
        end
    end
endmodule

// File: rtl/f2i_round.sv
// Applies one of four rounding directions to an unsigned integer part
// using guard and sticky bits; the sign steers the directed modes.
module f2i_round
    import f2i_pkg::*;
(
    input  logic [XLEN-1:0] int_part,
    input  logic            guard,
    input  logic            sticky,
    input  logic            sign,
    input  rmode_e          rm,
    output logic [XLEN:0]   mag,
    output logic            lost
);
    logic inc;

    // Decide the increment from the rounding direction and discarded bits.
    always_comb begin
        lost = guard | sticky;
        case (rm)
            RM_NEAR: inc = guard & (sticky | int_part[0]);
            RM_ZERO: inc = 1'b0;
            RM_UP:   inc = lost & ~sign;
            RM_DOWN: inc = lost & sign;
            default: inc = 1'b0;
        endcase
        mag = {1'b0, int_part} + {{XLEN{1'b0}}, inc};
    end
endmodule

// File: rtl/f2i_limit.sv
// Applies the selected overflow/NaN policy and target width/signedness
// to a rounded magnitude, and produces the extended result word and flags.
module f2i_limit
    import f2i_pkg::*;
(
    input  logic            sign,
    input  logic            is_nan,
    input  logic            is_inf,
    input  logic            big,
    input  logic [XLEN:0]   mag,
    input  logic            lost,
    input  policy_e         policy,
    input  logic            wide64,
    input  logic            signed_out,
    output logic [XLEN-1:0] word,
    output logic            invalid,
    output logic            inexact
);
    localparam int NW = 2;
    localparam logic [XLEN:0]   ONE_L = {{XLEN{1'b0}}, 1'b1};
    localparam logic [XLEN-1:0] ONE_W = {{(XLEN-1){1'b0}}, 1'b1};

    logic [XLEN:0]   lim_pos_s [NW];
    logic [XLEN:0]   lim_pos_u [NW];
    logic [XLEN:0]   lim_neg_s [NW];
    logic [XLEN-1:0] word_min  [NW];

    // Bounds for each supported target width.
    for (genvar g = 0; g < NW; g++) begin : g_bound
        localparam int W = (g == 0) ? HALF : XLEN;
        assign lim_pos_s[g] = (ONE_L << (W - 1)) - ONE_L;
        assign lim_pos_u[g] = (ONE_L << W) - ONE_L;
        assign lim_neg_s[g] = ONE_L << (W - 1);
        assign word_min[g]  = ~((ONE_W << (W - 1)) - ONE_W);
    end

    logic [XLEN:0]   pos_lim;
    logic [XLEN:0]   neg_lim;
    logic            ovf;
    logic            special;
    logic [XLEN-1:0] twos;
    logic [XLEN-1:0] wrapped;
    logic [XLEN-1:0] sat_word;
    logic [XLEN-1:0] nan_word;

    // Select bounds, form the in-range value and the saturation words.
    always_comb begin
        pos_lim  = signed_out ? lim_pos_s[wide64] : lim_pos_u[wide64];
        neg_lim  = signed_out ? lim_neg_s[wide64] : '0;
        ovf      = big | is_inf | (sign ? (mag > neg_lim) : (mag > pos_lim));
        special  = is_nan | is_inf;
        twos     = sign ? (~mag[XLEN-1:0] + ONE_W) : mag[XLEN-1:0];
        wrapped  = twos;
        if (!wide64)
            wrapped[XLEN-1:HALF] = signed_out ? {(XLEN-HALF){twos[HALF-1]}} : '0;
        sat_word = sign ? (signed_out ? word_min[wide64] : '0) : pos_lim[XLEN-1:0];
        nan_word = (policy == POL_SATZ) ? '0 : (signed_out ? word_min[wide64] : '0);
    end

    // Pick the result word and flags according to the policy.
    always_comb begin
        if (policy == POL_WRAP) begin
            word    = special ? '0 : wrapped;
            invalid = 1'b0;
            inexact = ~special & lost;
        end else if (is_nan) begin
            word    = nan_word;
            invalid = 1'b1;
            inexact = 1'b0;
        end else if (ovf) begin
            word    = sat_word;
            invalid = 1'b1;
            inexact = 1'b0;
        end else begin
            word    = wrapped;
            invalid = 1'b0;
            inexact = lost;
        end
    end
endmodule

// File: rtl/f2i_convert.sv
// Top of the float-to-integer converter: unpack, round, limit, then one
// output register stage with the compare-with-zero field.
// Assumes a synchronous active-low reset; data registers load only on requests.
module f2i_convert
    import f2i_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [63:0]     fp_in,
    input  logic [1:0]      policy,
    input  logic            force_trunc,
    input  logic [1:0]      rmode,
    input  logic            wide64,
    input  logic            signed_out,
    input  logic            rc_en,
    output logic            out_valid,
    output logic [63:0]     result,
    output logic            invalid,
    output logic            inexact,
    output logic [2:0]      cr_field
);
    logic            sign, is_nan, is_inf, big, guard, sticky, lost;
    logic [XLEN-1:0] int_part;
    logic [XLEN:0]   mag;
    logic [XLEN-1:0] word;
    logic            inv_c, inx_c;
    logic [2:0]      cr_c;
    rmode_e          rm_eff;

    assign rm_eff = force_trunc ? RM_ZERO : rmode_e'(rmode);

    f2i_unpack u_unpack (
        .fp(fp_in), .sign(sign), .is_nan(is_nan), .is_inf(is_inf), .big(big),
        .int_part(int_part), .guard(guard), .sticky(sticky)
    );

    f2i_round u_round (
        .int_part(int_part), .guard(guard), .sticky(sticky), .sign(sign),
        .rm(rm_eff), .mag(mag), .lost(lost)
    );

    f2i_limit u_limit (
        .sign(sign), .is_nan(is_nan), .is_inf(is_inf), .big(big), .mag(mag),
        .lost(lost), .policy(policy_e'(policy)), .wide64(wide64),
        .signed_out(signed_out), .word(word), .invalid(inv_c), .inexact(inx_c)
    );

    // Signed compare of the result word with zero.
    always_comb begin
        if (!rc_en)              cr_c = 3'b000;
        else if (word[XLEN-1])   cr_c = 3'b100;
        else if (word != '0)     cr_c = 3'b010;
        else                     cr_c = 3'b001;
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            invalid   <= 1'b0;
            inexact   <= 1'b0;
            cr_field  <= 3'b000;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result   <= word;
                invalid  <= inv_c;
                inexact  <= inx_c;
                cr_field <= cr_c;
            end
        end
    end
endmodule

// File: rtl/f2i_convert_chk.sv
// Property checker for f2i_convert, attached by bind below.
module f2i_convert_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  policy,
    input logic        wide64,
    input logic        signed_out,
    input logic        rc_en,
    input logic        out_valid,
    input logic [63:0] result,
    input logic        invalid,
    input logic        inexact,
    input logic [2:0]  cr_field
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid == $past(in_valid));

    // R1
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> ($stable(result) && $stable(cr_field)));

    // R9
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(invalid && inexact));

    // R10
    cr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cr_field));

    // R10
    cr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && !$past(rc_en)) |-> cr_field == 3'b000);

    // R5
    wrap_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(policy) == 2'b10) |-> !invalid);

    // R8
    sext_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && !$past(wide64) && $past(signed_out))
        |-> result[63:32] == {32{result[31]}});

    // R8
    zext_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && !$past(wide64) && !$past(signed_out))
        |-> result[63:32] == 32'd0);
endmodule

bind f2i_convert f2i_convert_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .policy(policy),
    .wide64(wide64), .signed_out(signed_out), .rc_en(rc_en),
    .out_valid(out_valid), .result(result), .invalid(invalid),
    .inexact(inexact), .cr_field(cr_field)
);

// File: tb/tb_f2i_convert.sv
`timescale 1ns/1ps
module tb_f2i_convert;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] fp_in = '0;
    logic [1:0]  policy = '0;
    logic        force_trunc = 1'b0;
    logic [1:0]  rmode = '0;
    logic        wide64 = 1'b1;
    logic        signed_out = 1'b1;
    logic        rc_en = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic        invalid;
    logic        inexact;
    logic [2:0]  cr_field;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    f2i_convert dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fp_in(fp_in),
        .policy(policy), .force_trunc(force_trunc), .rmode(rmode),
        .wide64(wide64), .signed_out(signed_out), .rc_en(rc_en),
        .out_valid(out_valid), .result(result), .invalid(invalid),
        .inexact(inexact), .cr_field(cr_field)
    );

    localparam real TWO32 = 4294967296.0;
    localparam real TWO64 = 18446744073709551616.0;

    function automatic logic [63:0] to_word(input real x);
        real hi, lo;
        hi = $floor(x / TWO32);
        lo = x - hi * TWO32;
        return {32'(longint'(hi)), 32'(longint'(lo))};
    endfunction

    function automatic logic [63:0] extend(input logic [63:0] w, input bit w64, input bit sg);
        if (w64) return w;
        return sg ? {{32{w[31]}}, w[31:0]} : {32'd0, w[31:0]};
    endfunction

    function automatic real round_r(input real v, input logic [1:0] rm);
        real fl, d, h;
        case (rm)
            2'b01: return (v >= 0.0) ? $floor(v) : $ceil(v);
            2'b10: return $ceil(v);
            2'b11: return $floor(v);
            default: begin
                fl = $floor(v);
                d  = v - fl;
                if (d > 0.5) return fl + 1.0;
                if (d < 0.5) return fl;
                h = fl / 2.0;
                return (h == $floor(h)) ? fl : fl + 1.0;
            end
        endcase
    endfunction

    // Reference model built from R2..R9 and R12.
    function automatic void ref_model(input logic [63:0] b, input logic [1:0] pol,
        input bit ft, input logic [1:0] rm, input bit w64, input bit sg,
        output logic [63:0] res, output bit inv, output bit inx);
        bit   nan, inf, neg;
        real  v, r, a, m, lo, hiex;
        int   n;
        logic [63:0] maxw, minw, w;
        nan = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
        inf = (b[62:52] == 11'h7FF) && (b[51:0] == 0);
        n = w64 ? 64 : 32;
        maxw = sg ? ((64'd1 << (n - 1)) - 64'd1) : (w64 ? '1 : 64'h0000_0000_FFFF_FFFF);
        minw = sg ? (w64 ? 64'h8000_0000_0000_0000 : 64'hFFFF_FFFF_8000_0000) : 64'd0;
        inv = 0; inx = 0; res = '0;
        if (pol == 2'b10) begin
            if (nan || inf) return;
            v = $bitstoreal(b);
            r = round_r(v, ft ? 2'b01 : rm);
            inx = (r != v);
            neg = (r < 0.0);
            a = neg ? -r : r;
            m = a - $floor(a / TWO64) * TWO64;
            w = to_word(m);
            if (neg) w = -w;
            res = extend(w, w64, sg);
            return;
        end
        if (nan) begin
            res = (pol == 2'b01) ? 64'd0 : minw;
            inv = 1;
            return;
        end
        v = $bitstoreal(b);
        if (inf) begin
            res = (v > 0.0) ? maxw : minw;
            inv = 1;
            return;
        end
        r = round_r(v, ft ? 2'b01 : rm);
        lo   = sg ? -(2.0 ** (n - 1)) : 0.0;
        hiex = sg ? (2.0 ** (n - 1)) : (2.0 ** n);
        if (r >= hiex || r < lo) begin
            res = (v > 0.0) ? maxw : minw;
            inv = 1;
            return;
        end
        inx = (r != v);
        neg = (r < 0.0);
        a = neg ? -r : r;
        w = to_word(a);
        if (neg) w = -w;
        res = extend(w, w64, sg);
    endfunction

    function automatic logic [2:0] exp_cr(input logic [63:0] r, input bit rc);
        if (!rc) return 3'b000;
        if (r[63]) return 3'b100;
        if (r != 0) return 3'b010;
        return 3'b001;
    endfunction

    // Present one request at a falling edge and check one cycle later.
    task automatic run(input logic [63:0] b, input logic [1:0] pol, input bit ft,
        input logic [1:0] rm, input bit w64, input bit sg, input bit rc,
        input logic [63:0] er, input bit ei, input bit ex, input string tag);
        logic [2:0] ec;
        fp_in = b; policy = pol; force_trunc = ft; rmode = rm;
        wide64 = w64; signed_out = sg; rc_en = rc; in_valid = 1'b1;
        @(negedge clk);
        ec = exp_cr(er, rc);
        checks++;
        if (!out_valid || result !== er || invalid !== ei || inexact !== ex || cr_field !== ec) begin
            errors++;
            $display("FAIL %s in=%h pol=%0d ft=%0b rm=%0d w64=%0b sg=%0b: got v=%0b r=%h inv=%0b inx=%0b cr=%b exp r=%h inv=%0b inx=%0b cr=%b",
                tag, b, pol, ft, rm, w64, sg, out_valid, result, invalid, inexact, cr_field,
                er, ei, ex, ec);
        end
    endtask

    task automatic run_ref(input logic [63:0] b, input logic [1:0] pol, input bit ft,
        input logic [1:0] rm, input bit w64, input bit sg, input bit rc, input string tag);
        logic [63:0] er; bit ei, ex;
        ref_model(b, pol, ft, rm, w64, sg, er, ei, ex);
        run(b, pol, ft, rm, w64, sg, rc, er, ei, ex, tag);
    endtask

    function automatic logic [63:0] rnd_fp();
        logic [10:0] e;
        logic [63:0] m;
        int cls;
        cls = int'($urandom % 10);
        m = {$urandom, $urandom};
        if (cls < 6)       e = 11'(1020 + ($urandom % 70));
        else if (cls == 6) e = 11'd0;
        else if (cls == 7) e = 11'h7FF;
        else               e = 11'($urandom);
        if (($urandom % 4) == 0) m[30:0] = '0;
        return {1'($urandom), e, m[51:0]};
    endfunction

    initial begin
        logic [63:0] held;
        string tag;
        logic [1:0] pol;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R11: reset state
        checks++;
        if (out_valid !== 1'b0 || result !== 64'd0 || invalid !== 1'b0 || inexact !== 1'b0 || cr_field !== 3'b000) begin
            errors++;
            $display("FAIL R11 reset: got v=%0b r=%h inv=%0b inx=%0b cr=%b exp all zero",
                out_valid, result, invalid, inexact, cr_field);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2: rounding directions on 2.5, -2.5, 3.5
        run(64'h4004000000000000, 2'b00, 0, 2'b00, 1, 1, 0, 64'd2, 0, 1, "R2 rne 2.5");
        run(64'h4004000000000000, 2'b00, 0, 2'b10, 1, 1, 0, 64'd3, 0, 1, "R2 up 2.5");
        run(64'h4004000000000000, 2'b00, 0, 2'b11, 1, 1, 0, 64'd2, 0, 1, "R2 down 2.5");
        run(64'hC004000000000000, 2'b00, 0, 2'b00, 1, 1, 0, -64'sd2, 0, 1, "R2 rne -2.5");
        run(64'hC004000000000000, 2'b00, 0, 2'b11, 1, 1, 0, -64'sd3, 0, 1, "R2 down -2.5");
        run(64'h400C000000000000, 2'b00, 0, 2'b00, 1, 1, 0, 64'd4, 0, 1, "R2 rne 3.5");
        run(64'h4004000000000000, 2'b00, 1, 2'b10, 1, 1, 0, 64'd2, 0, 1, "R2 force trunc");
        // R3: saturate, NaN to minimum
        run(64'h7FF8000000000000, 2'b00, 0, 2'b00, 0, 1, 0, 64'hFFFFFFFF80000000, 1, 0, "R3 nan s32");
        run(64'h7FF8000000000000, 2'b00, 0, 2'b00, 1, 1, 0, 64'h8000000000000000, 1, 0, "R3 nan s64");
        run(64'h41E0000000000000, 2'b00, 0, 2'b00, 0, 1, 0, 64'h000000007FFFFFFF, 1, 0, "R3 2^31 s32");
        run(64'h7FF0000000000000, 2'b00, 0, 2'b00, 1, 0, 0, 64'hFFFFFFFFFFFFFFFF, 1, 0, "R3 inf u64");
        run(64'hFFF0000000000000, 2'b00, 0, 2'b00, 1, 1, 0, 64'h8000000000000000, 1, 0, "R3 -inf s64");
        // R4: NaN to zero
        run(64'h7FF8000000000000, 2'b01, 0, 2'b00, 0, 1, 0, 64'd0, 1, 0, "R4 nan");
        run(64'h41E0000000000000, 2'b01, 0, 2'b00, 0, 1, 0, 64'h000000007FFFFFFF, 1, 0, "R4 2^31 s32");
        // R5: wrap
        run(64'h7FF8000000000000, 2'b10, 0, 2'b00, 1, 1, 0, 64'd0, 0, 0, "R5 nan");
        run(64'h7FF0000000000000, 2'b10, 0, 2'b00, 1, 1, 0, 64'd0, 0, 0, "R5 inf");
        run(64'h41F0000000500000, 2'b10, 0, 2'b00, 0, 1, 0, 64'd5, 0, 0, "R5 2^32+5");
        run(64'h41E0000000000000, 2'b10, 0, 2'b00, 0, 1, 0, 64'hFFFFFFFF80000000, 0, 0, "R5 2^31 s32");
        // R6: reserved policy behaves as saturate
        run(64'h7FF8000000000000, 2'b11, 0, 2'b00, 0, 1, 0, 64'hFFFFFFFF80000000, 1, 0, "R6 nan");
        // R7: unsigned negatives
        run(64'hBFF0000000000000, 2'b00, 0, 2'b00, 0, 0, 0, 64'd0, 1, 0, "R7 -1 u32");
        run(64'hBFD3333333333333, 2'b00, 0, 2'b01, 0, 0, 0, 64'd0, 0, 1, "R7 -0.3 u32");
        // R8: extension of 32-bit results
        run(64'h41E65A0BC0000000, 2'b00, 0, 2'b00, 0, 0, 0, 64'h00000000B2D05E00, 0, 0, "R8 3e9 u32");
        run(64'hC004000000000000, 2'b00, 0, 2'b00, 0, 1, 0, 64'hFFFFFFFFFFFFFFFE, 0, 1, "R8 -2 s32");
        // R10: compare field
        run(64'hC004000000000000, 2'b00, 0, 2'b00, 1, 1, 1, -64'sd2, 0, 1, "R10 negative");
        run(64'h0000000000000000, 2'b00, 0, 2'b00, 1, 1, 1, 64'd0, 0, 0, "R10 zero");
        run(64'h4004000000000000, 2'b00, 0, 2'b00, 1, 1, 1, 64'd2, 0, 1, "R10 positive");
        // R12: subnormals
        run(64'h0000000000000001, 2'b00, 0, 2'b10, 1, 1, 0, 64'd1, 0, 1, "R12 denorm up");
        run(64'h8000000000000001, 2'b00, 0, 2'b11, 1, 1, 0, -64'sd1, 0, 1, "R12 denorm down");
        run(64'h0000000000000001, 2'b00, 0, 2'b00, 1, 1, 0, 64'd0, 0, 1, "R12 denorm rne");

        // R1: idle cycle holds outputs
        held = result;
        fp_in = 64'h4059000000000000; in_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== held) begin
            errors++;
            $display("FAIL R1 hold: got v=%0b r=%h exp v=0 r=%h", out_valid, result, held);
        end

        // Random stimulus against the reference model (R2..R10, R12).
        for (int i = 0; i < 4000; i++) begin
            pol = 2'($urandom);
            case (pol)
                2'b00: tag = "R3 rand";
                2'b01: tag = "R4 rand";
                2'b10: tag = "R5 rand";
                default: tag = "R6 rand";
            endcase
            run_ref(rnd_fp(), pol, 1'($urandom), 2'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom), tag);
        end

        in_valid = 1'b0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule